// File: doc/BRIEF.md
# Configuration Space Access Decoder

This block sits at the configuration entry of a peripheral that has several functions. Each request carries a 16-bit routing key, a byte offset, an access width, a direction flag and write data. The block compares the bus and device fields of the key with the straps for its own slot. It then selects one function and reads or writes that function's 256-byte configuration space. Multibyte values are laid out little-endian across the four byte lanes of a 32-bit word.

Every function holds three read-only identification fields and a writable store for the remaining bytes. A request that targets another slot, or a function that is not built, gets a miss response. A request with a bad width or a bad alignment gets an error response. Every accepted request produces one response, one cycle later.

Top module: `cfg_space_decoder`

## Requirements
- R1: The key is split as bus = key[15:8], device = key[7:3], function = key[2:0]. A request hits only when bus equals `strap_bus`, device equals `strap_dev`, and bit `function` of parameter FN_MASK (default 8'h87, so functions 0, 1, 2 and 7) is set.
- R2: A request that does not hit returns `rsp_miss`=1, `rsp_err`=0 and `rsp_rdata`=32'hFFFFFFFF, and it changes no stored byte.
- R3: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low after a cycle without a request.
- R4: `req_size` encodes 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. Code 3 is rejected as an error.
- R5: A 16-bit access needs offset bit 0 clear, and a 32-bit access needs offset bits 1:0 clear. A hit that breaks this rule, or that uses size code 3, returns `rsp_err`=1, `rsp_miss`=0 and read data of all ones, and writes nothing.
- R6: The byte at offset off+k is carried in bits 8k+7:8k of `req_wdata` and of `rsp_rdata`. Read data is right-justified and its unused upper bits are zero. A write response returns zero data.
- R7: A write stores its bytes at the clock edge that accepts it, so a read in the very next cycle returns the new value.
- R8: Bytes 0x00–0x03 read as vendor ID 16'h1D5C at 0x00 and device ID 16'h4200 plus the function number at 0x02. Bytes 0x08–0x0B read as revision 8'h03 at 0x08 and class code 24'h0C8001 at 0x09. Writes to these bytes are ignored.
- R9: A write changes only the addressed function's bytes. No other function is affected.
- R10: After reset, `rsp_valid` is low and every writable byte of every function reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_bus | input | 8 | Bus number of this slot |
| strap_dev | input | 5 | Device number of this slot |
| req_valid | input | 1 | Request present this cycle |
| req_key | input | 16 | Bus/device/function routing key |
| req_off | input | 8 | Byte offset in the function space |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_miss | output | 1 | Request was not for this slot or function |
| rsp_err | output | 1 | Width or alignment was illegal |

## Verification
The assertions assume that the straps stay constant and that the request fields have known values in every cycle in which `req_valid` is high. They also assume that requests may arrive back to back with no handshake. The stimulus sets the straps once before reset is released and keeps them there. It then drives fully defined fields on every cycle, including idle cycles. The stimulus mixes hitting keys, keys with the wrong bus or device, functions that are not built, illegal size codes and misaligned offsets. This makes every response kind occur, including back-to-back write-then-read pairs.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int KEY_W  = 16;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
    import cfg_pkg::*;
#(
    parameter int              NUM_FN  = 8,
    parameter logic [NUM_FN-1:0] FN_MASK = 8'h87
) (
    input  logic [KEY_W-1:0] key,
    input  logic [BUS_W-1:0] strap_bus,
    input  logic [DEV_W-1:0] strap_dev,
    output logic             hit,
    output logic [FN_W-1:0]  fn_num,
    output logic [NUM_FN-1:0] fn_sel
);
    logic [BUS_W-1:0] bus_f;
    logic [DEV_W-1:0] dev_f;
    logic             slot_ok;

    assign bus_f   = key[KEY_W-1 -: BUS_W];
    assign dev_f   = key[FN_W +: DEV_W];
    assign fn_num  = key[FN_W-1:0];
    assign slot_ok = (bus_f == strap_bus) && (dev_f == strap_dev);

    for (genvar i = 0; i < NUM_FN; i++) begin : g_sel
        if (FN_MASK[i]) begin : g_built
            assign fn_sel[i] = slot_ok && (fn_num == FN_W'(i));
        end else begin : g_absent
            assign fn_sel[i] = 1'b0;
        end
    end

    assign hit = |fn_sel;
endmodule

// File: rtl/cfg_lane_ctrl.sv
module cfg_lane_ctrl
    import cfg_pkg::*;
#(
    parameter int SPACE_BYTES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFF_W-1:0]     off,
    input  logic [1:0]           size,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    word_rd,
    output logic                 legal,
    output logic [$clog2(SPACE_BYTES/LANES)-1:0] word_idx,
    output logic [LANES-1:0]     byte_en,
    output logic [DATA_W-1:0]    wr_word,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int WIDX_W = $clog2(SPACE_BYTES / LANES);

    acc_size_e        sz;
    logic [1:0]       lane;
    logic [DATA_W-1:0] shifted;

    assign sz       = acc_size_e'(size);
    assign lane     = off[1:0];
    assign word_idx = off[2 +: WIDX_W];

    always_comb begin
        legal   = 1'b0;
        byte_en = '0;
        case (sz)
            SZ_BYTE: begin
                legal   = 1'b1;
                byte_en = LANES'(4'b0001) << lane;
            end
            SZ_HALF: begin
                legal   = ~lane[0];
                byte_en = LANES'(4'b0011) << lane;
            end
            SZ_WORD: begin
                legal   = (lane == 2'd0);
                byte_en = '1;
            end
            default: begin
                legal   = 1'b0;
                byte_en = '0;
            end
        endcase
        if (!legal) byte_en = '0;
    end

    assign wr_word = wdata << {lane, 3'b000};
    assign shifted = word_rd >> {lane, 3'b000};

    always_comb begin
        case (sz)
            SZ_BYTE: rd_data = {24'h0, shifted[7:0]};
            SZ_HALF: rd_data = {16'h0, shifted[15:0]};
            default: rd_data = shifted;
        endcase
    end

    // R6: a legal full-word access drives every lane
    p_word_all_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && sz == SZ_WORD) |-> byte_en == '1);
    // R5: an illegal access enables no lane
    p_no_lane_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> byte_en == '0);
    // R6: a legal byte access drives exactly one lane
    p_one_lane_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && sz == SZ_BYTE) |-> $countones(byte_en) == 1);
endmodule

// File: rtl/cfg_fn_space.sv
module cfg_fn_space
    import cfg_pkg::*;
#(
    parameter int          FN_IDX      = 0,
    parameter int          SPACE_BYTES = 256,
    parameter logic [15:0] VENDOR_ID   = 16'h1D5C,
    parameter logic [15:0] DEVICE_ID   = 16'h4200,
    parameter logic [7:0]  REV_ID      = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h0C8001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(SPACE_BYTES/LANES)-1:0] word_idx,
    input  logic [LANES-1:0]     byte_en,
    input  logic [DATA_W-1:0]    wr_word,
    output logic [DATA_W-1:0]    rd_word
);
    localparam int          WORDS    = SPACE_BYTES / LANES;
    localparam int          WIDX_W   = $clog2(WORDS);
    localparam logic [15:0] DEV_THIS = DEVICE_ID + 16'(FN_IDX);
    localparam logic [WIDX_W-1:0] ID_WORD    = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] CLASS_WORD = WIDX_W'(2);

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;
    logic                         ro_hit;

    assign ro_hit = (word_idx == ID_WORD) || (word_idx == CLASS_WORD);

    always_comb begin
        mem_d = mem_q;
        if (wr_en && !ro_hit) begin
            for (int b = 0; b < LANES; b++) begin
                if (byte_en[b]) mem_d[word_idx][b*8 +: 8] = wr_word[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        if (word_idx == ID_WORD)         rd_word = {DEV_THIS, VENDOR_ID};
        else if (word_idx == CLASS_WORD) rd_word = {CLASS_CODE, REV_ID};
        else                             rd_word = mem_q[word_idx];
    end

    // R9: storage of this function holds while it is not written
    p_hold_unwritten_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));
    // R8: a write aimed at an identification word leaves storage alone
    p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ro_hit) |=> $stable(mem_q));
endmodule

// File: rtl/cfg_space_decoder.sv
module cfg_space_decoder
    import cfg_pkg::*;
#(
    parameter int                 NUM_FN      = 8,
    parameter logic [NUM_FN-1:0]  FN_MASK     = 8'h87,
    parameter int                 SPACE_BYTES = 256,
    parameter logic [15:0]        VENDOR_ID   = 16'h1D5C,
    parameter logic [15:0]        DEVICE_ID   = 16'h4200,
    parameter logic [7:0]         REV_ID      = 8'h03,
    parameter logic [23:0]        CLASS_CODE  = 24'h0C8001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  strap_bus,
    input  logic [4:0]  strap_dev,
    input  logic        req_valid,
    input  logic [15:0] req_key,
    input  logic [7:0]  req_off,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_miss,
    output logic        rsp_err
);
    localparam int WIDX_W = $clog2(SPACE_BYTES / LANES);

    logic                hit;
    logic [FN_W-1:0]     fn_num;
    logic [NUM_FN-1:0]   fn_sel;
    logic                legal;
    logic [WIDX_W-1:0]   word_idx;
    logic [LANES-1:0]    byte_en;
    logic [DATA_W-1:0]   wr_word;
    logic [DATA_W-1:0]   rd_data;
    logic [DATA_W-1:0]   word_rd;
    logic [DATA_W-1:0]   fn_rd [NUM_FN];
    logic                do_write;
    rsp_t                rsp_d, rsp_q;

    cfg_key_match #(.NUM_FN(NUM_FN), .FN_MASK(FN_MASK)) u_key (
        .key(req_key), .strap_bus(strap_bus), .strap_dev(strap_dev),
        .hit(hit), .fn_num(fn_num), .fn_sel(fn_sel)
    );

    cfg_lane_ctrl #(.SPACE_BYTES(SPACE_BYTES)) u_lane (
        .clk(clk), .rst_n(rst_n), .off(req_off), .size(req_size),
        .wdata(req_wdata), .word_rd(word_rd), .legal(legal),
        .word_idx(word_idx), .byte_en(byte_en), .wr_word(wr_word),
        .rd_data(rd_data)
    );

    assign do_write = req_valid && hit && legal && req_write;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
        if (FN_MASK[i]) begin : g_built
            cfg_fn_space #(
                .FN_IDX(i), .SPACE_BYTES(SPACE_BYTES), .VENDOR_ID(VENDOR_ID),
                .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE)
            ) u_space (
                .clk(clk), .rst_n(rst_n), .wr_en(do_write && fn_sel[i]),
                .word_idx(word_idx), .byte_en(byte_en), .wr_word(wr_word),
                .rd_word(fn_rd[i])
            );
        end else begin : g_absent
            assign fn_rd[i] = '1;
        end
    end

    assign word_rd = fn_rd[fn_num];

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (!hit) begin
                rsp_d.miss  = 1'b1;
                rsp_d.rdata = '1;
            end else if (!legal) begin
                rsp_d.err   = 1'b1;
                rsp_d.rdata = '1;
            end else if (!req_write) begin
                rsp_d.rdata = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_err   = rsp_q.err;

    // R3: one response in the cycle after each request
    p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: a miss carries all-ones data and no error
    p_miss_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_rdata == '1 && !rsp_err));
    // R5: an error carries all-ones data
    p_err_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_rdata == '1);
    // R2: a request for another slot never reaches storage
    p_miss_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |-> !do_write);
    // R6: a legal byte read has zero upper bits
    p_byte_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && legal && !req_write && req_size == 2'd0)
        |=> rsp_rdata[31:8] == 24'h0);
endmodule

// File: tb/cfg_space_decoder_bench.sv
`timescale 1ns/1ps
module cfg_space_decoder_bench;
    localparam logic [7:0]  SB   = 8'h3A;
    localparam logic [4:0]  SD   = 5'h0B;
    localparam logic [7:0]  MASK = 8'h87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_key = '0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_miss, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int unsigned model [8][256];
    bit          exp_v, exp_m, exp_e;
    logic [31:0] exp_d;
    string       exp_tag = "R10";

    always #2.5 clk = ~clk;

    cfg_space_decoder u_cfg_space_decoder (
        .clk(clk), .rst_n(rst_n), .strap_bus(SB), .strap_dev(SD),
        .req_valid(req_valid), .req_key(req_key), .req_off(req_off),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_miss(rsp_miss), .rsp_err(rsp_err)
    );

    function automatic logic [15:0] mk(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f);
        return {b, d, f};
    endfunction

    function automatic bit ro_byte(input int o);
        return (o < 4) || (o >= 8 && o < 12);
    endfunction

    task automatic check_prev();
        checks++;
        if (rsp_valid !== exp_v ||
            (exp_v && (rsp_miss !== exp_m || rsp_err !== exp_e || rsp_rdata !== exp_d))) begin
            fails++;
            $display("FAIL %s: got v=%0d m=%0d e=%0d d=%h expected v=%0d m=%0d e=%0d d=%h",
                     exp_tag, rsp_valid, rsp_miss, rsp_err, rsp_rdata,
                     exp_v, exp_m, exp_e, exp_d);
        end
    endtask

    // One clock: check the response to the previous cycle, then drive this one.
    task automatic cyc(input bit v, input logic [15:0] key, input int off,
                       input int size, input bit wr, input logic [31:0] wd,
                       input string tag);
        int fn;
        bit hit, bad;
        @(negedge clk);
        check_prev();
        req_valid = v; req_key = key; req_off = 8'(off);
        req_size = 2'(size); req_write = wr; req_wdata = wd;
        exp_tag = tag;
        exp_v = v; exp_m = 0; exp_e = 0; exp_d = '0;
        if (v) begin
            fn  = int'(key[2:0]);
            hit = (key[15:8] == SB) && (key[7:3] == SD) && MASK[fn];
            bad = (size == 3) || (size == 1 && off[0]) || (size == 2 && off[1:0] != 0);
            if (!hit) begin
                exp_m = 1; exp_d = '1;
            end else if (bad) begin
                exp_e = 1; exp_d = '1;
            end else begin
                for (int k = 0; k < (1 << size); k++) begin
                    if (wr) begin
                        if (!ro_byte(off + k)) model[fn][off + k] = (wd >> (8 * k)) & 8'hFF;
                    end else begin
                        exp_d = exp_d | (32'(model[fn][off + k]) << (8 * k));
                    end
                end
            end
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, '0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        for (int f = 0; f < 8; f++) begin
            for (int o = 0; o < 256; o++) model[f][o] = 0;
            model[f][0] = 8'h5C; model[f][1] = 8'h1D;
            model[f][2] = f;     model[f][3] = 8'h42;
            model[f][8] = 8'h03; model[f][9] = 8'h01;
            model[f][10] = 8'h80; model[f][11] = 8'h0C;
        end
        exp_v = 0; exp_m = 0; exp_e = 0; exp_d = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: quiet output and zeroed storage after reset
        idle("R10");
        cyc(1, mk(SB, SD, 0), 8'h10, 2, 0, '0, "R10");
        cyc(1, mk(SB, SD, 7), 8'hFC, 2, 0, '0, "R10");
        // R8: identification values, several widths
        cyc(1, mk(SB, SD, 0), 8'h00, 2, 0, '0, "R8");
        cyc(1, mk(SB, SD, 1), 8'h02, 1, 0, '0, "R8");
        cyc(1, mk(SB, SD, 2), 8'h0B, 0, 0, '0, "R8");
        cyc(1, mk(SB, SD, 7), 8'h08, 2, 0, '0, "R8");
        cyc(1, mk(SB, SD, 0), 8'h00, 2, 1, 32'hDEADBEEF, "R8");
        cyc(1, mk(SB, SD, 0), 8'h00, 2, 0, '0, "R8");
        cyc(1, mk(SB, SD, 1), 8'h0A, 1, 1, 32'h0000FFFF, "R8");
        cyc(1, mk(SB, SD, 1), 8'h08, 2, 0, '0, "R8");
        // R7 / R6: write then read back in the next cycle, lane placement
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 1, 32'h11223344, "R7");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R7");
        for (int k = 0; k < 4; k++) cyc(1, mk(SB, SD, 0), 8'h40 + k, 0, 0, '0, "R6");
        cyc(1, mk(SB, SD, 0), 8'h42, 1, 0, '0, "R6");
        cyc(1, mk(SB, SD, 0), 8'h41, 0, 1, 32'hFFFFFFAB, "R6");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R6");
        cyc(1, mk(SB, SD, 0), 8'h42, 1, 1, 32'h0000BEEF, "R6");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 1, 32'h0, "R6");
        idle("R3");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R6");
        // R9: functions are isolated
        cyc(1, mk(SB, SD, 1), 8'h40, 2, 1, 32'hCAFEF00D, "R9");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R9");
        cyc(1, mk(SB, SD, 2), 8'h40, 2, 0, '0, "R9");
        cyc(1, mk(SB, SD, 1), 8'h40, 2, 0, '0, "R9");
        // R1 / R2: wrong bus, wrong device, absent function
        cyc(1, mk(SB + 8'd1, SD, 0), 8'h40, 2, 1, 32'h99999999, "R2");
        cyc(1, mk(SB, SD + 5'd1, 0), 8'h40, 2, 1, 32'h88888888, "R2");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R2");
        cyc(1, mk(SB, SD, 3), 8'h40, 2, 0, '0, "R1");
        cyc(1, mk(SB, SD, 5), 8'h40, 0, 1, 32'h5, "R1");
        cyc(1, mk(8'h00, 5'h00, 0), 8'h00, 2, 0, '0, "R1");
        // R4 / R5: size code and alignment
        cyc(1, mk(SB, SD, 0), 8'h41, 1, 0, '0, "R5");
        cyc(1, mk(SB, SD, 0), 8'h42, 2, 1, 32'h77777777, "R5");
        cyc(1, mk(SB, SD, 0), 8'h43, 1, 1, 32'h6666, "R5");
        cyc(1, mk(SB, SD, 0), 8'h40, 3, 1, 32'h55555555, "R4");
        cyc(1, mk(SB, SD, 0), 8'h40, 3, 0, '0, "R4");
        cyc(1, mk(SB, SD, 0), 8'h40, 2, 0, '0, "R5");
        cyc(1, mk(SB + 8'd1, SD, 0), 8'h41, 1, 0, '0, "R2");
        // R3: idle gaps alternate with requests
        idle("R3"); idle("R3");
        cyc(1, mk(SB, SD, 2), 8'h80, 0, 0, '0, "R3");
        idle("R3");
        // Mixed traffic against the reference model
        for (int n = 0; n < 600; n++) begin
            logic [15:0] key;
            int sel = $urandom_range(0, 9);
            key = mk(sel == 0 ? SB ^ 8'h01 : SB, sel == 1 ? SD ^ 5'h02 : SD,
                     3'($urandom_range(0, 7)));
            cyc($urandom_range(0, 5) != 0, key,
                $urandom_range(0, 3) == 0 ? $urandom_range(0, 15) : 8'h40 + $urandom_range(0, 15),
                $urandom_range(0, 5) == 5 ? 3 : $urandom_range(0, 2),
                $urandom_range(0, 1) == 1, $urandom, "R6");
        end
        idle("R3");
        idle("R3");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no finish, expected finish before limit");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule